// File: doc/BRIEF.md
# Two-Port RAM with Per-Port Write Modes

This block is a synchronous memory with two ports, A and B, that work independently of each other and share only the storage bits. Each port has its own enable, write strobe, address, write data and read data. Every input is captured on the rising clock edge. The array and the read outputs change only at an edge on which the port is enabled. Each port takes a compile-time write mode, which sets what its read output shows on a write cycle: the previous contents of the word, the word being written, or the value it already held. Each port can also add one output register stage for timing.

The two ports may have different data widths over the same total bit count. A narrow port then addresses sub-words of the wider port's words. The low bits of the narrow address pick the lane inside the wide word, and lane 0 is the least-significant slice. Both ports run from one clock. This makes same-cycle collisions exact: a reader sees the old bits, and when both ports write the same bits, port A's data is stored.

Top module: `tdp_ram`

## Requirements
- R1: A read on an enabled cycle with the write strobe low puts the addressed word on the port's read output after the next rising edge. With the extra stage off, the latency is one cycle.
- R2: While a port's enable is low, its read output does not change, and neither does its extra output stage.
- R3: In read-first mode (mode code 0), an enabled write shows the word's previous contents on that port's read output.
- R4: In write-first mode (mode code 1), an enabled write shows that port's own write data on its read output.
- R5: In no-change mode (mode code 2), an enabled write leaves that port's read output at its previous value.
- R6: With the extra stage on, the output shows the value that the first stage held before the current enabled edge. The result of an access therefore appears after the second enabled edge.
- R7: A port of width W with address n covers array bits n*W up to n*W+W-1. So a narrow address selects its lane in the wide word with its low bits, and lane 0 holds the least-significant bits.
- R8: When one port writes bits that the other port reads at the same edge, the reader returns the data stored before that edge.
- R9: When both ports write overlapping bits at the same edge, the overlapping bits take port A's data.
- R10: While rst_n is low at a rising edge, both read outputs and both extra stages become zero. The array itself is not cleared.

Port widths: AW_A = log2(TOTAL_BITS/A_W) and AW_B = log2(TOTAL_BITS/B_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset for the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write strobe, used only while a_en is high |
| a_addr | input | AW_A | Port A word address |
| a_wdata | input | A_W | Port A write data |
| a_rdata | output | A_W | Port A read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write strobe, used only while b_en is high |
| b_addr | input | AW_B | Port B word address |
| b_wdata | input | B_W | Port B write data |
| b_rdata | output | B_W | Port B read data |

## Verification
A wrong lane mapping or a lost write stays hidden in the array until some port reads those bits. A mismatch then shows one cycle after that read, or two cycles with the extra stage on. A wrong write mode, a wrong collision priority or an output stage that moves while disabled shows on the read output at the very next edge. For this reason the stimulus mixes dense traffic in a small window, where the ports often share bits, with occasional accesses across the whole array. Three width and mode configurations are each compared against a bit-level model of the array.

// File: rtl/tdp_pkg.sv
// Shared types for the two-port RAM.
// Assumes: nothing beyond a SystemVerilog-2017 tool.
package tdp_pkg;

    // What a port's read output shows on a write cycle
    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

endpackage

// File: rtl/tdp_array.sv
// Bit storage shared by two ports of possibly different widths.
// Stored as lanes of the narrower width. Each port writes whole words, and
// port A wins on lanes that both ports write at the same edge.
// Reads are combinational from the stored lanes (the values before the edge).
// Assumes: widths are powers of two, the wider width is a multiple of the
// narrower, and each depth is at least 2.
module tdp_array #(
    parameter int TOTAL_BITS = 1024,
    parameter int A_W        = 8,
    parameter int B_W        = 32,
    localparam int AW_A      = $clog2(TOTAL_BITS / A_W),
    localparam int AW_B      = $clog2(TOTAL_BITS / B_W)
) (
    input  logic            clk,
    input  logic            a_wr,
    input  logic [AW_A-1:0] a_addr,
    input  logic [A_W-1:0]  a_wd,
    input  logic            b_wr,
    input  logic [AW_B-1:0] b_addr,
    input  logic [B_W-1:0]  b_wd,
    output logic [A_W-1:0]  a_rd,
    output logic [B_W-1:0]  b_rd
);
    localparam int LW    = (A_W < B_W) ? A_W : B_W;
    localparam int LANES = TOTAL_BITS / LW;
    localparam int KA    = A_W / LW;
    localparam int KB    = B_W / LW;

    logic [TOTAL_BITS-1:0] flat;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int IA = i / KA;
        localparam int SA = i % KA;
        localparam int IB = i / KB;
        localparam int SB = i % KB;
        logic [LW-1:0] bits_q;
        logic          hit_a;
        logic          hit_b;

        assign hit_a = a_wr && (a_addr == AW_A'(IA));
        assign hit_b = b_wr && (b_addr == AW_B'(IB));

        // Lane store: port A has priority over port B
        always_ff @(posedge clk) begin
            if (hit_a) begin
                bits_q <= a_wd[SA*LW +: LW];
            end else if (hit_b) begin
                bits_q <= b_wd[SB*LW +: LW];
            end
        end

        assign flat[i*LW +: LW] = bits_q;
    end

    // Word fetch for each port from the flat bit view
    assign a_rd = flat[int'(a_addr)*A_W +: A_W];
    assign b_rd = flat[int'(b_addr)*B_W +: B_W];

endmodule

// File: rtl/tdp_port_out.sv
// Read-output path of one port: the first register applies the write mode,
// and an optional second register adds a cycle. Both registers move only on
// enabled cycles.
// Assumes: rd is the array word at the port address before the edge.
module tdp_port_out
    import tdp_pkg::*;
#(
    parameter int     W    = 8,
    parameter wmode_e MODE = WM_READ_FIRST,
    parameter bit     PIPE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         we,
    input  logic [W-1:0] wd,
    input  logic [W-1:0] rd,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q;

    // First output register, chosen by access kind and write mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
        end else if (en) begin
            if (!we) begin
                s1_q <= rd;
            end else begin
                case (MODE)
                    WM_READ_FIRST:  s1_q <= rd;
                    WM_WRITE_FIRST: s1_q <= wd;
                    default:        s1_q <= s1_q;
                endcase
            end
        end
    end

    if (PIPE) begin : g_pipe
        logic [W-1:0] s2_q;

        // Extra stage, advanced only with the port enable
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s2_q <= '0;
            end else if (en) begin
                s2_q <= s1_q;
            end
        end
        assign dout = s2_q;
    end else begin : g_direct
        assign dout = s1_q;
    end

endmodule

// File: rtl/tdp_ram.sv
// Two-port RAM on one clock, with a write mode and an optional output stage
// per port, and independent port widths over the same bit array.
// Assumes: power-of-two widths, one width a multiple of the other, and
// depths of at least 2. The array contents are not reset.
module tdp_ram
    import tdp_pkg::*;
#(
    parameter int     TOTAL_BITS = 1024,
    parameter int     A_W        = 8,
    parameter int     B_W        = 32,
    parameter wmode_e A_MODE     = WM_READ_FIRST,
    parameter wmode_e B_MODE     = WM_WRITE_FIRST,
    parameter bit     A_PIPE     = 1'b0,
    parameter bit     B_PIPE     = 1'b1,
    localparam int    AW_A       = $clog2(TOTAL_BITS / A_W),
    localparam int    AW_B       = $clog2(TOTAL_BITS / B_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_en,
    input  logic            a_we,
    input  logic [AW_A-1:0] a_addr,
    input  logic [A_W-1:0]  a_wdata,
    output logic [A_W-1:0]  a_rdata,
    input  logic            b_en,
    input  logic            b_we,
    input  logic [AW_B-1:0] b_addr,
    input  logic [B_W-1:0]  b_wdata,
    output logic [B_W-1:0]  b_rdata
);
    logic [A_W-1:0] a_rd_w;
    logic [B_W-1:0] b_rd_w;
    logic           a_wr;
    logic           b_wr;

    assign a_wr = a_en && a_we;
    assign b_wr = b_en && b_we;

    tdp_array #(
        .TOTAL_BITS(TOTAL_BITS),
        .A_W       (A_W),
        .B_W       (B_W)
    ) u_array (
        .clk   (clk),
        .a_wr  (a_wr),
        .a_addr(a_addr),
        .a_wd  (a_wdata),
        .b_wr  (b_wr),
        .b_addr(b_addr),
        .b_wd  (b_wdata),
        .a_rd  (a_rd_w),
        .b_rd  (b_rd_w)
    );

    tdp_port_out #(
        .W   (A_W),
        .MODE(A_MODE),
        .PIPE(A_PIPE)
    ) u_out_a (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (a_en),
        .we   (a_we),
        .wd   (a_wdata),
        .rd   (a_rd_w),
        .dout (a_rdata)
    );

    tdp_port_out #(
        .W   (B_W),
        .MODE(B_MODE),
        .PIPE(B_PIPE)
    ) u_out_b (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (b_en),
        .we   (b_we),
        .wd   (b_wdata),
        .rd   (b_rd_w),
        .dout (b_rdata)
    );

endmodule

// File: rtl/tdp_ram_chk.sv
// Property checker for tdp_ram, bound to it below.
// Assumes: it sees the array read words of both ports next to the ports.
module tdp_ram_chk
    import tdp_pkg::*;
#(
    parameter int     TOTAL_BITS = 1024,
    parameter int     A_W        = 8,
    parameter int     B_W        = 32,
    parameter wmode_e A_MODE     = WM_READ_FIRST,
    parameter wmode_e B_MODE     = WM_WRITE_FIRST,
    parameter bit     A_PIPE     = 1'b0,
    parameter bit     B_PIPE     = 1'b1,
    localparam int    AW_A       = $clog2(TOTAL_BITS / A_W),
    localparam int    AW_B       = $clog2(TOTAL_BITS / B_W)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            a_en,
    input logic            a_we,
    input logic [AW_A-1:0] a_addr,
    input logic [A_W-1:0]  a_wdata,
    input logic [A_W-1:0]  a_rdata,
    input logic            b_en,
    input logic            b_we,
    input logic [AW_B-1:0] b_addr,
    input logic [B_W-1:0]  b_wdata,
    input logic [B_W-1:0]  b_rdata,
    input logic [A_W-1:0]  a_rd,
    input logic [B_W-1:0]  b_rd
);
    logic ab_overlap;

    // Do the bit spans addressed by the two ports intersect?
    always_comb begin
        ab_overlap = (int'(a_addr) * A_W < int'(b_addr) * B_W + B_W) &&
                     (int'(b_addr) * B_W < int'(a_addr) * A_W + A_W);
    end

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (a_rdata == '0 && b_rdata == '0));

    p_hold_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> $stable(a_rdata));

    p_hold_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_rdata));

    p_a_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we) |=> (a_addr != $past(a_addr)) || (a_rd == $past(a_wdata)));

    p_b_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && b_we && !(a_en && a_we && ab_overlap))
        |=> (b_addr != $past(b_addr)) || (b_rd == $past(b_wdata)));

    if (!A_PIPE && A_MODE == WM_READ_FIRST) begin : g_a_rf
        p_rf_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (a_en && a_we) |=> a_rdata == $past(a_rd));
    end else if (!A_PIPE && A_MODE == WM_WRITE_FIRST) begin : g_a_wf
        p_wf_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (a_en && a_we) |=> a_rdata == $past(a_wdata));
    end else if (!A_PIPE) begin : g_a_nc
        p_nc_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (a_en && a_we) |=> $stable(a_rdata));
    end

    if (!B_PIPE && B_MODE == WM_READ_FIRST) begin : g_b_rf
        p_rf_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (b_en && b_we) |=> b_rdata == $past(b_rd));
    end else if (!B_PIPE && B_MODE == WM_WRITE_FIRST) begin : g_b_wf
        p_wf_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (b_en && b_we) |=> b_rdata == $past(b_wdata));
    end else if (!B_PIPE) begin : g_b_nc
        p_nc_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (b_en && b_we) |=> $stable(b_rdata));
    end

endmodule

bind tdp_ram tdp_ram_chk #(
    .TOTAL_BITS(TOTAL_BITS),
    .A_W       (A_W),
    .B_W       (B_W),
    .A_MODE    (A_MODE),
    .B_MODE    (B_MODE),
    .A_PIPE    (A_PIPE),
    .B_PIPE    (B_PIPE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_en   (a_en),
    .a_we   (a_we),
    .a_addr (a_addr),
    .a_wdata(a_wdata),
    .a_rdata(a_rdata),
    .b_en   (b_en),
    .b_we   (b_we),
    .b_addr (b_addr),
    .b_wdata(b_wdata),
    .b_rdata(b_rdata),
    .a_rd   (a_rd_w),
    .b_rd   (b_rd_w)
);

// File: tb/sim_tdp_ram_cfg.sv
// One configuration of tdp_ram with its own stimulus and bit-level model.
// Inputs are driven on the falling edge; outputs are compared there as well.
module sim_tdp_ram_cfg
    import tdp_pkg::*;
#(
    parameter int     TOTAL_BITS = 1024,
    parameter int     A_W        = 8,
    parameter int     B_W        = 32,
    parameter wmode_e A_MODE     = WM_READ_FIRST,
    parameter wmode_e B_MODE     = WM_WRITE_FIRST,
    parameter bit     A_PIPE     = 1'b0,
    parameter bit     B_PIPE     = 1'b1,
    parameter int     SEED       = 1
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_fail,
    output logic done
);
    localparam int AW_A = $clog2(TOTAL_BITS / A_W);
    localparam int AW_B = $clog2(TOTAL_BITS / B_W);
    localparam int DA   = TOTAL_BITS / A_W;
    localparam int DB   = TOTAL_BITS / B_W;

    logic            a_en, a_we, b_en, b_we;
    logic [AW_A-1:0] a_addr;
    logic [AW_B-1:0] b_addr;
    logic [A_W-1:0]  a_wdata, a_rdata;
    logic [B_W-1:0]  b_wdata, b_rdata;

    tdp_ram #(
        .TOTAL_BITS(TOTAL_BITS), .A_W(A_W), .B_W(B_W),
        .A_MODE(A_MODE), .B_MODE(B_MODE), .A_PIPE(A_PIPE), .B_PIPE(B_PIPE)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    logic [TOTAL_BITS-1:0] mdl;
    logic [A_W-1:0] a_s1, a_s2, a_exp;
    logic [B_W-1:0] b_s1, b_s2, b_exp;
    string tag_a, tag_b;
    bit    chk_on;

    function automatic string tag_for(wmode_e m, bit pipe, logic en, logic we);
        if (!en)                   return "R2";
        if (pipe)                  return "R6";
        if (!we)                   return "R1";
        if (m == WM_READ_FIRST)    return "R3";
        if (m == WM_WRITE_FIRST)   return "R4";
        return "R5";
    endfunction

    task automatic compare(input logic [31:0] act, input logic [31:0] exp,
                           input string tag, input string port);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s port %s (cfg seed %0d): got %h expected %h",
                     tag, port, SEED, act, exp);
        end
    endtask

    // One cycle: check the previous step's results, then drive and model the next
    task automatic step(input logic ea, input logic wa, input int adda, input logic [A_W-1:0] da,
                        input logic eb, input logic wb, input int addb, input logic [B_W-1:0] db,
                        input string ovr);
        logic [A_W-1:0] olda, na;
        logic [B_W-1:0] oldb, nb;
        @(negedge clk);
        if (chk_on) begin
            compare(32'(a_rdata), 32'(a_exp), tag_a, "A");
            compare(32'(b_rdata), 32'(b_exp), tag_b, "B");
        end
        a_en = ea; a_we = wa; a_addr = AW_A'(adda); a_wdata = da;
        b_en = eb; b_we = wb; b_addr = AW_B'(addb); b_wdata = db;
        olda = mdl[adda*A_W +: A_W];
        oldb = mdl[addb*B_W +: B_W];
        if (ea) begin
            na = a_s1;
            if (!wa || A_MODE == WM_READ_FIRST) na = olda;
            else if (A_MODE == WM_WRITE_FIRST)  na = da;
            a_s2 = a_s1;
            a_s1 = na;
        end
        if (eb) begin
            nb = b_s1;
            if (!wb || B_MODE == WM_READ_FIRST) nb = oldb;
            else if (B_MODE == WM_WRITE_FIRST)  nb = db;
            b_s2 = b_s1;
            b_s1 = nb;
        end
        a_exp = A_PIPE ? a_s2 : a_s1;
        b_exp = B_PIPE ? b_s2 : b_s1;
        // B first, then A, so A owns any shared bits (R9)
        if (eb && wb) mdl[addb*B_W +: B_W] = db;
        if (ea && wa) mdl[adda*A_W +: A_W] = da;
        tag_a = (ovr != "") ? ovr : tag_for(A_MODE, A_PIPE, ea, wa);
        tag_b = (ovr != "") ? ovr : tag_for(B_MODE, B_PIPE, eb, wb);
    endtask

    task automatic idle(input string ovr);
        step(1'b0, 1'b0, 0, '0, 1'b0, 1'b0, 0, '0, ovr);
    endtask

    initial begin
        n_chk = 0; n_fail = 0; done = 1'b0; chk_on = 1'b0;
        a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
        b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
        mdl = '0; a_s1 = '0; a_s2 = '0; b_s1 = '0; b_s2 = '0; a_exp = '0; b_exp = '0;
        tag_a = "R10"; tag_b = "R10";
        void'($urandom(SEED));
        wait (rst_n === 1'b1);
        // R10: outputs cleared by reset
        chk_on = 1'b1;
        idle("R2");
        chk_on = 1'b0;
        // Fill the whole array through port A, then refresh both outputs
        for (int i = 0; i < DA; i++) step(1, 1, i, A_W'($urandom), 0, 0, 0, '0, "");
        step(1, 0, 0, '0, 1, 0, 0, '0, "R1");
        step(1, 0, 1, '0, 1, 0, 1, '0, "R1");
        chk_on = 1'b1;
        idle("R2");
        idle("R2");
        // R7: narrow words land in lanes of wide words, both directions
        for (int i = 0; i < 64 / A_W; i++) step(1, 1, 64 / A_W + i, A_W'($urandom), 0, 0, 0, '0, "R7");
        for (int i = 0; i < 64 / B_W; i++) step(0, 0, 0, '0, 1, 0, 64 / B_W + i, '0, "R7");
        for (int i = 0; i < 64 / B_W; i++) step(0, 0, 0, '0, 1, 1, 64 / B_W + i, B_W'($urandom), "R7");
        for (int i = 0; i < 64 / A_W; i++) step(1, 0, 64 / A_W + i, '0, 0, 0, 0, '0, "R7");
        step(1, 0, 0, '0, 1, 0, 0, '0, "R7");
        step(1, 0, 0, '0, 1, 0, 0, '0, "R7");
        // R9: both ports write bit 0 region in the same cycle
        step(1, 1, 0, A_W'(32'h5A5A_5A5A), 1, 1, 0, B_W'(32'hC3C3_C3C3), "R9");
        step(1, 0, 0, '0, 1, 0, 0, '0, "R9");
        step(1, 0, 0, '0, 1, 0, 0, '0, "R9");
        step(1, 0, 0, '0, 1, 0, 0, '0, "R9");
        // R8: A writes while B reads the same bits
        step(1, 1, 0, A_W'(32'h1234_9876), 1, 0, 0, '0, "R8");
        step(1, 0, 0, '0, 1, 0, 0, '0, "R8");
        step(1, 0, 0, '0, 1, 0, 0, '0, "R8");
        // Random mix: mostly a small shared window, sometimes the whole array
        for (int n = 0; n < 1500; n++) begin
            int aa, ab;
            aa = ($urandom % 4 == 0) ? int'($urandom % DA) : int'($urandom % (64 / A_W));
            ab = ($urandom % 4 == 0) ? int'($urandom % DB) : int'($urandom % (64 / B_W));
            step($urandom % 4 != 0, $urandom % 2 == 0, aa, A_W'($urandom),
                 $urandom % 4 != 0, $urandom % 2 == 0, ab, B_W'($urandom), "");
        end
        idle("R2");
        idle("R2");
        done = 1'b1;
    end

endmodule

// File: tb/sim_tdp_ram.sv
// Top bench: clock, reset and watchdog, with three width and mode configurations.
`timescale 1ns/1ps
module sim_tdp_ram;
    import tdp_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   c0, f0, c1, f1, c2, f2;
    logic d0, d1, d2;

    always #2.5 clk = ~clk;

    sim_tdp_ram_cfg #(.TOTAL_BITS(1024), .A_W(8), .B_W(32), .A_MODE(WM_READ_FIRST),
                      .B_MODE(WM_WRITE_FIRST), .A_PIPE(1'b0), .B_PIPE(1'b1), .SEED(11))
        h0 (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .done(d0));

    sim_tdp_ram_cfg #(.TOTAL_BITS(1024), .A_W(4), .B_W(16), .A_MODE(WM_NO_CHANGE),
                      .B_MODE(WM_READ_FIRST), .A_PIPE(1'b0), .B_PIPE(1'b1), .SEED(23))
        h1 (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .done(d1));

    sim_tdp_ram_cfg #(.TOTAL_BITS(1024), .A_W(32), .B_W(8), .A_MODE(WM_WRITE_FIRST),
                      .B_MODE(WM_NO_CHANGE), .A_PIPE(1'b1), .B_PIPE(1'b0), .SEED(37))
        h2 (.clk(clk), .rst_n(rst_n), .n_chk(c2), .n_fail(f2), .done(d2));

    initial begin
        int cyc;
        int wd_fail;
        cyc = 0;
        wd_fail = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        while (!(d0 && d1 && d2) && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!(d0 && d1 && d2)) begin
            wd_fail = 1;
            $display("FAIL watchdog: got %0d cycles without completion, expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 c0 + c1 + c2 + wd_fail, f0 + f1 + f2 + wd_fail);
        $finish;
    end

endmodule